// File: doc/BRIEF.md
# Input-Capture Timer with Edge-Triggered Clear

This block is an 8-bit free-running up-counter paired with one capture input. A small control byte sets four things: which clock advances the counter (one of three divided system clocks or a divided sub-clock), which capture-input edge produces a capture event, which capture-input edges reset the counter to zero, and whether counter wrap is reported on the overflow interrupt output.

On a capture event the present counter value is copied into a capture register and a sticky capture flag is set. That flag drives the capture interrupt output. Counter wrap sets a sticky overflow flag. Each flag is cleared by a one-cycle strobe. Because the clear edge and the capture edge are chosen separately, the block can measure a period, which is the count latched just before a clear on the same edge. It can also time from one edge to the opposite edge.

Top module: `capture_timer`

## Requirements
- R1: After reset, the control byte, counter, capture register and both interrupt outputs are all zero.
- R2: A write stores `ctrl_wdata_i[5:0]` into the control byte, which takes effect from the next cycle. The readback shows these six bits, and bits 7:6 always read 0.
- R3: Control bits 1:0 select the count tick. 00 gives a tick every 64 system clocks and 01 every 32. 10 gives a tick every 2 system clocks. 11 gives a tick on every fourth `sub_tick_i` pulse. The system-clock dividers and the sub-clock pulse counter run continuously from reset, whichever selection is active. Without a tick or a clear, the counter holds.
- R4: The counter wraps from 0xFF to 0x00, and that wrap sets the overflow flag. `ovf_irq_o` is the overflow flag ANDed with control bit 5.
- R5: The capture input passes through two synchronizing flip-flops. An edge presented before clock edge N acts at clock edge N+2.
- R6: Control bit 4 selects the capture edge: 0 for rising, 1 for falling. On that edge `capture_o` takes the counter value of that cycle, and the capture flag (`cap_irq_o`) sets.
- R7: Control bits 3:2 select which edges clear the counter: 00 for none, 01 for falling, 10 for rising, 11 for both.
- R8: When a clear and a tick occur in the same cycle, the counter becomes 0 and no overflow is recorded.
- R9: Both flags are sticky. The flag clear inputs (`ovf_clr_i`, `cap_clr_i`) clear them when pulsed high for one cycle. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_tick_i | input | 1 | Single-cycle sub-clock enable pulse |
| cap_i | input | 1 | Asynchronous capture input |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| ctrl_rdata_o | output | 8 | Control byte readback |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| cap_clr_i | input | 1 | Capture flag clear strobe |
| count_o | output | 8 | Counter value |
| capture_o | output | 8 | Last captured counter value |
| ovf_irq_o | output | 1 | Overflow interrupt |
| cap_irq_o | output | 1 | Capture interrupt (capture flag) |

## Verification
The hardest case to reach from the ports is a synchronized clear edge that lands in the same cycle as a count tick, especially when the counter is at 0xFF. That cycle decides both the clear priority and the suppressed overflow. The stimulus steps through all 64 control settings. It toggles the capture input and pulses the sub-clock and flag strobes at random cycles, and spends long stretches on the divide-by-2 selection, so edges fall on every tick phase and the counter wraps many times. A behavioural model tracks the divider phase and the synchronizer samples and is compared every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CK_DIV64 = 2'b00,
    CK_DIV32 = 2'b01,
    CK_DIV2  = 2'b10,
    CK_SUB4  = 2'b11
  } ck_sel_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_FALL = 2'b01,
    CLR_RISE = 2'b10,
    CLR_BOTH = 2'b11
  } clr_mode_e;

  typedef struct packed {
    logic      ovf_ie;
    logic      cap_on_fall;
    clr_mode_e clr_mode;
    ck_sel_e   ck_sel;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int unsigned DIV_W = 6,
  parameter int unsigned SUB_W = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sub_tick_i,
  input  ck_sel_e sel_i,
  output logic    tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sub_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      if (sub_tick_i) sub_q <= sub_q + 1'b1;
    end
  end

  always_comb begin
    unique case (sel_i)
      CK_DIV64: tick_o = &div_q;
      CK_DIV32: tick_o = &div_q[DIV_W-2:0];
      CK_DIV2:  tick_o = div_q[0];
      default:  tick_o = sub_tick_i & (&sub_q);
    endcase
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_N:0] sh_q;  // [SYNC_N-1] current, [SYNC_N] previous

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], pin_i};
  end

  assign rise_o =  sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
  assign fall_o = ~sh_q[SYNC_N-1] &  sh_q[SYNC_N];
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned SUB_W  = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sub_tick_i,
  input  logic             cap_i,
  input  logic             ctrl_we_i,
  input  logic [7:0]       ctrl_wdata_i,
  output logic [7:0]       ctrl_rdata_o,
  input  logic             ovf_clr_i,
  input  logic             cap_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             ovf_irq_o,
  output logic             cap_irq_o
);
  tmr_ctrl_t        ctrl_q;
  logic             tick, rise, fall, clr_hit, cap_ev, wrap, ovf_flag;
  logic [CNT_W-1:0] cnt_q, cap_q;
  logic             unused_wdata;

  assign unused_wdata = ^ctrl_wdata_i[7:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= tmr_ctrl_t'(ctrl_wdata_i[CTRL_W-1:0]);
  end

  tmr_prescale #(.DIV_W(DIV_W), .SUB_W(SUB_W)) u_pre (
    .clk_i, .rst_ni, .sub_tick_i, .sel_i(ctrl_q.ck_sel), .tick_o(tick)
  );

  tmr_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .pin_i(cap_i), .rise_o(rise), .fall_o(fall)
  );

  always_comb begin
    unique case (ctrl_q.clr_mode)
      CLR_FALL: clr_hit = fall;
      CLR_RISE: clr_hit = rise;
      CLR_BOTH: clr_hit = rise | fall;
      default:  clr_hit = 1'b0;
    endcase
  end

  assign cap_ev = ctrl_q.cap_on_fall ? fall : rise;
  assign wrap   = tick & ~clr_hit & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      if (clr_hit)   cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
      if (cap_ev)    cap_q <= cnt_q;
    end
  end

  tmr_flag u_ovf (.clk_i, .rst_ni, .set_i(wrap),   .clr_i(ovf_clr_i), .q_o(ovf_flag));
  tmr_flag u_cap (.clk_i, .rst_ni, .set_i(cap_ev), .clr_i(cap_clr_i), .q_o(cap_irq_o));

  assign ctrl_rdata_o = 8'(ctrl_q);
  assign count_o      = cnt_q;
  assign capture_o    = cap_q;
  assign ovf_irq_o    = ovf_flag & ctrl_q.ovf_ie;
endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             clr_hit,
  input logic             cap_ev,
  input logic             ovf_flag,
  input logic             cap_clr_i,
  input logic             cap_irq_o,
  input logic [7:0]       ctrl_rdata_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] capture_o
);
  assert_clear_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit |=> count_o == '0);

  assert_wrap_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !clr_hit && (&count_o)) |=> ovf_flag);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !clr_hit) |=> $stable(count_o));

  assert_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> (cap_irq_o && capture_o == $past(count_o)));

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_irq_o && !cap_clr_i) |=> cap_irq_o);

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[7:6] == 2'b00);
endmodule

bind capture_timer capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .tick, .clr_hit, .cap_ev, .ovf_flag, .cap_clr_i,
  .cap_irq_o, .ctrl_rdata_o, .count_o, .capture_o
);

// File: tb/sim_capture_timer.sv
`timescale 1ns/1ps
module sim_capture_timer;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sub_tick = 1'b0, cap = 1'b0, we = 1'b0, ovf_clr = 1'b0, cap_clr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, count, capture;
  logic       ovf_irq, cap_irq;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .sub_tick_i(sub_tick), .cap_i(cap),
    .ctrl_we_i(we), .ctrl_wdata_i(wdata), .ctrl_rdata_o(rdata),
    .ovf_clr_i(ovf_clr), .cap_clr_i(cap_clr), .count_o(count),
    .capture_o(capture), .ovf_irq_o(ovf_irq), .cap_irq_o(cap_irq)
  );

  // behavioural reference
  int m_ctrl, m_div, m_sub, m_cnt, m_cap;
  bit m_ovf, m_cf;
  bit m_smp[$];  // synchronizer history, newest at front

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_div = 0; m_sub = 0; m_cnt = 0; m_cap = 0;
      m_ovf = 0; m_cf = 0; m_smp = '{0, 0, 0};
    end else begin
      bit cur, prv, rs, fl, tk, clr, ev;
      int sel, cm;
      cur = m_smp[1]; prv = m_smp[2];
      rs = cur && !prv; fl = !cur && prv;
      sel = m_ctrl % 4; cm = (m_ctrl / 4) % 4;
      case (sel)
        0: tk = (m_div == 63);
        1: tk = (m_div % 32 == 31);
        2: tk = (m_div % 2 == 1);
        default: tk = sub_tick && (m_sub == 3);
      endcase
      clr = (cm == 1 && fl) || (cm == 2 && rs) || (cm == 3 && (rs || fl));
      ev  = ((m_ctrl / 16) % 2 == 1) ? fl : rs;
      if (ev) m_cap = m_cnt;
      if (ev) m_cf = 1; else if (cap_clr) m_cf = 0;
      if (!clr && tk && m_cnt == 255) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (clr) m_cnt = 0; else if (tk) m_cnt = (m_cnt + 1) % 256;
      if (we) m_ctrl = wdata % 64;
      m_div = (m_div + 1) % 64;
      if (sub_tick) m_sub = (m_sub + 1) % 4;
      m_smp.push_front(cap);
      void'(m_smp.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cyc++;
    chk("R3/R5/R7/R8 count", count, m_cnt);
    chk("R5/R6 capture", capture, m_cap);
    chk("R4/R9 ovf_irq", ovf_irq, int'(m_ovf && ((m_ctrl / 32) % 2 == 1)));
    chk("R6/R9 cap_irq", cap_irq, m_cf);
    chk("R2 rdata", rdata, m_ctrl);
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic wr(int v);
    @(negedge clk); we = 1; wdata = 8'(v);
    @(negedge clk); we = 0;
  endtask

  task automatic run(int n, int cap_rate, int clr_rate);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sub_tick = ($urandom % 3) == 0;
      if (($urandom % cap_rate) == 0) cap = ~cap;
      ovf_clr = ($urandom % clr_rate) == 0;
      cap_clr = ($urandom % clr_rate) == 0;
    end
    @(negedge clk); sub_tick = 0; ovf_clr = 0; cap_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1: reset state
    chk("R1 count", count, 0);
    chk("R1 capture", capture, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 irqs", {ovf_irq, cap_irq}, 0);
    rst_n = 1;
    // R2: reserved bits read 0
    wr(8'hFF);
    @(negedge clk) chk("R2 readback", rdata, 8'h3F);
    // R3: default divide-by-64, quiet input
    wr(8'h00);
    run(400, 1000000, 1000000);
    // R5/R6: single rising edge, rising capture, no clear
    wr(8'h02);
    run(40, 1000000, 1000000);
    @(negedge clk) cap = 1;
    run(10, 1000000, 1000000);
    // sweep every control setting with random edges and strobes
    for (int c = 0; c < 64; c++) begin
      wr(c);
      run(((c % 4) == 2) ? 1200 : 500, 12, 40);
    end
    // R4/R8: fast count, overflow enabled, clear on both edges, sparse edges
    wr(8'h2E);
    run(6000, 97, 300);
    wr(8'h26);
    run(6000, 61, 300);
    // R9: clear strobe with no new events
    wr(8'h22);
    @(negedge clk) begin ovf_clr = 1; cap_clr = 1; end
    @(negedge clk) begin ovf_clr = 0; cap_clr = 0; end
    run(20, 1000000, 1000000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule